// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Trigger Capture

This block buffers complete three-axis samples. Each entry holds an X, a Y and a Z word. A 2-bit mode input selects one of four behaviours. In bypass the buffer holds nothing. In fill mode it takes samples until it is full and then drops new ones. In stream mode it keeps the newest samples and discards the oldest. Trigger mode streams until a trigger pulse arrives, then trims the buffer to the last n samples and continues as a fill buffer.

A consumer reads the oldest entry from the head outputs and removes it with a one-cycle pop. A registered watermark flag compares the entry count with a programmable level. The trigger-taken indication is routed to one of two interrupt outputs by a select bit. After one trigger is taken, trigger mode stays disarmed until the mode passes through bypass.

Top module: `axis3_sample_fifo`

## Requirements
- R1: The buffer holds at most DEPTH (32) entries. `count` never exceeds DEPTH. Entries leave in arrival order, and while `count` is non-zero the head outputs show the oldest entry, with X, Y and Z from the same sample.
- R2: The mode field is encoded 00 bypass, 01 fill, 10 stream, 11 trigger. While the mode is bypass, no sample is stored and pops have no effect. From the clock after the first bypass edge, `count` reads 0 and all stored data is gone.
- R3: In fill mode, a sample presented while the buffer is full is dropped, even if a pop is presented in the same cycle. The stored contents stay unchanged.
- R4: In stream mode, a sample presented while the buffer is full, with no pop, is accepted and the oldest entry is discarded. The buffer then holds the newest 32 samples.
- R5: In stream mode with the buffer full, a push and a pop in the same cycle keep `count` at 32. The head advances by one entry.
- R6: `wmark` is registered alongside `count`. It is 1 exactly when the level is non-zero and `count` is at or above the level. A level of 0 keeps it at 0.
- R7: In trigger mode before a trigger, samples are kept as in stream mode. A trigger pulse causes one trim cycle. After the trim cycle the buffer holds the newest min(count, level) samples.
- R8: `busy` is high for exactly one cycle: the cycle after the trigger is sampled. Pushes and pops presented while `busy` is high are ignored.
- R9: After the trim, trigger mode behaves as fill mode. Further trigger pulses are ignored until the mode has been bypass and then trigger again.
- R10: `trig_taken` rises on the clock that samples an accepted trigger and stays high until bypass. It appears on `irq_a` when `trig_sel` is 0 and on `irq_b` when `trig_sel` is 1.
- R11: A pop while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New sample present this cycle |
| smp_x | input | AXIS_W | X word of the new sample |
| smp_y | input | AXIS_W | Y word of the new sample |
| smp_z | input | AXIS_W | Z word of the new sample |
| trig_in | input | 1 | Trigger event pulse |
| mode | input | 2 | Buffer mode (00 bypass, 01 fill, 10 stream, 11 trigger) |
| level | input | LVL_W | Watermark level and trigger retain count |
| trig_sel | input | 1 | Routes the trigger indication: 0 to irq_a, 1 to irq_b |
| pop | input | 1 | Remove the oldest entry |
| head_x | output | AXIS_W | X word of the oldest entry |
| head_y | output | AXIS_W | Y word of the oldest entry |
| head_z | output | AXIS_W | Z word of the oldest entry |
| count | output | CNT_W | Number of stored entries |
| wmark | output | 1 | Watermark flag |
| busy | output | 1 | Trim in progress |
| trig_taken | output | 1 | A trigger has been accepted |
| irq_a | output | 1 | Trigger indication, first output |
| irq_b | output | 1 | Trigger indication, second output |

## Verification
The bench builds the block with its defaults: DEPTH 32, 16-bit axis words and a 5-bit level. At these values a full buffer is reached within a few dozen pushes. The stream wrap, the full-buffer drop in fill mode and the trim of 40 streamed samples down to 5 all happen within a few hundred cycles. The same level width covers a level of 0, a level below the fill and a level above it. These values let the bench trim an over-full ring and also fire a trigger on a buffer holding fewer samples than the level.

// File: rtl/s3f_pkg.sv
package s3f_pkg;
  typedef enum logic [1:0] {
    MD_OFF  = 2'b00,
    MD_FILL = 2'b01,
    MD_RING = 2'b10,
    MD_CAPT = 2'b11
  } s3f_mode_e;

  typedef enum logic [1:0] {
    TS_ARMED = 2'd0,
    TS_TRIM  = 2'd1,
    TS_HELD  = 2'd2
  } s3f_tstate_e;
endpackage

// File: rtl/s3f_store.sv
module s3f_store #(
  parameter int DEPTH = 32,
  parameter int W     = 48,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [W-1:0]     rd_data
);
  // Synchronous write, asynchronous read: distributed RAM inference.
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/s3f_ctrl.sv
module s3f_ctrl
  import s3f_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             trig_req,
  input  logic [LVL_W-1:0] level,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] rd_addr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             busy,
  output logic             taken
);
  s3f_mode_e   md;
  s3f_tstate_e ts_q, ts_d;
  logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CNT_W-1:0] lvl_ext;
  logic full, empty, trimming, fill_like;
  logic take_push, take_pop, evict;

  always_comb begin
    md        = s3f_mode_e'(mode_i);
    lvl_ext   = CNT_W'(level);
    full      = (cnt_q == CNT_W'(DEPTH));
    empty     = (cnt_q == '0);
    trimming  = (ts_q == TS_TRIM);
    fill_like = (md == MD_FILL) || (md == MD_CAPT && ts_q == TS_HELD);
    // R11: empty pops ignored; R8: nothing moves during trim
    take_pop  = pop_req && !empty && (md != MD_OFF) && !trimming;
    take_push = 1'b0;
    if (md != MD_OFF && !trimming)
      take_push = fill_like ? (push_req && !full) : push_req;  // R3 / R4
    evict     = take_push && full && !take_pop;                 // R4

    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_nxt = cnt_q;
    ts_d  = ts_q;
    if (md == MD_OFF) begin                                     // R2, R9 re-arm
      wr_d    = '0;
      rd_d    = '0;
      cnt_nxt = '0;
      ts_d    = TS_ARMED;
    end else if (trimming) begin                                // R7: one-cycle trim
      ts_d = TS_HELD;
      if (cnt_q > lvl_ext) begin
        rd_d    = rd_q + PTR_W'(cnt_q - lvl_ext);
        cnt_nxt = lvl_ext;
      end
    end else begin
      wr_d    = wr_q + PTR_W'(take_push);
      rd_d    = rd_q + PTR_W'(take_pop || evict);
      cnt_nxt = cnt_q + CNT_W'(take_push) - CNT_W'(take_pop) - CNT_W'(evict);
      if (md == MD_CAPT && ts_q == TS_ARMED && trig_req) ts_d = TS_TRIM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ts_q  <= TS_ARMED;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_nxt;
      ts_q  <= ts_d;
    end
  end

  assign wr_en   = take_push;
  assign wr_addr = wr_q;
  assign rd_addr = rd_q;
  assign busy    = trimming;
  assign taken   = (ts_q != TS_ARMED);
endmodule

// File: rtl/s3f_flags.sv
module s3f_flags #(
  parameter int CNT_W = 6,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [LVL_W-1:0] level,
  input  logic             taken,
  input  logic             sel,
  output logic             wmark,
  output logic             irq_a,
  output logic             irq_b
);
  // R6: registered so it lines up with the count register
  always_ff @(posedge clk) begin
    if (rst) wmark <= 1'b0;
    else     wmark <= (level != '0) && (cnt_nxt >= CNT_W'(level));
  end

  // R10: route the trigger indication
  assign irq_a = taken && !sel;
  assign irq_b = taken && sel;
endmodule

// File: rtl/axis3_sample_fifo.sv
module axis3_sample_fifo #(
  parameter int DEPTH  = 32,
  parameter int AXIS_W = 16,
  parameter int LVL_W  = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int ENT_W = 3 * AXIS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [AXIS_W-1:0] smp_x,
  input  logic [AXIS_W-1:0] smp_y,
  input  logic [AXIS_W-1:0] smp_z,
  input  logic              trig_in,
  input  logic [1:0]        mode,
  input  logic [LVL_W-1:0]  level,
  input  logic              trig_sel,
  input  logic              pop,
  output logic [AXIS_W-1:0] head_x,
  output logic [AXIS_W-1:0] head_y,
  output logic [AXIS_W-1:0] head_z,
  output logic [CNT_W-1:0]  count,
  output logic              wmark,
  output logic              busy,
  output logic              trig_taken,
  output logic              irq_a,
  output logic              irq_b
);
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [ENT_W-1:0] rd_data;
  logic [CNT_W-1:0] cnt_nxt;

  s3f_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode), .push_req(smp_valid), .pop_req(pop),
    .trig_req(trig_in), .level(level), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .cnt_q(count), .cnt_nxt(cnt_nxt), .busy(busy),
    .taken(trig_taken)
  );

  // R1: one entry carries all three axes of a sample
  s3f_store #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data({smp_x, smp_y, smp_z}),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  s3f_flags #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .level(level), .taken(trig_taken),
    .sel(trig_sel), .wmark(wmark), .irq_a(irq_a), .irq_b(irq_b)
  );

  assign {head_x, head_y, head_z} = rd_data;
endmodule

// File: rtl/s3f_checker.sv
module s3f_checker #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 5,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [LVL_W-1:0] level,
  input logic             smp_valid,
  input logic             pop,
  input logic [CNT_W-1:0] count,
  input logic             wmark,
  input logic             busy,
  input logic             trig_taken,
  input logic             irq_a,
  input logic             irq_b
);
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R1
  AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (count == '0)); // R2
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && count == CNT_W'(DEPTH) && !pop && !busy) |=> (count == CNT_W'(DEPTH))); // R3
  AST_RING_FULL: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && count == CNT_W'(DEPTH) && smp_valid && !busy) |=> (count == CNT_W'(DEPTH))); // R4
  AST_WM_LEVEL: assert property (@(posedge clk) disable iff (rst)
    wmark == (($past(level) != '0) && (count >= CNT_W'($past(level))))); // R6
  AST_TRIM_LEVEL: assert property (@(posedge clk) disable iff (rst)
    busy |=> (count <= CNT_W'($past(level)))); // R7
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R8
  AST_TAKEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_taken) |-> busy); // R8
  AST_TAKEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (trig_taken && mode != 2'b00) |=> trig_taken); // R9
  AST_IRQ_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_a, irq_b})); // R10
endmodule

bind axis3_sample_fifo s3f_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_chk (
  .clk(clk), .rst(rst), .mode(mode), .level(level), .smp_valid(smp_valid),
  .pop(pop), .count(count), .wmark(wmark), .busy(busy),
  .trig_taken(trig_taken), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/test_axis3_sample_fifo.sv
module test_axis3_sample_fifo;
  localparam int DEPTH  = 32;
  localparam int AXIS_W = 16;
  localparam int LVL_W  = 5;
  localparam int CNT_W  = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic              rst = 1'b1;
  logic              smp_valid = 1'b0;
  logic [AXIS_W-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic              trig_in = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic [LVL_W-1:0]  level = '0;
  logic              trig_sel = 1'b0;
  logic              pop = 1'b0;
  logic [AXIS_W-1:0] head_x, head_y, head_z;
  logic [CNT_W-1:0]  count;
  logic              wmark, busy, trig_taken, irq_a, irq_b;

  axis3_sample_fifo #(.DEPTH(DEPTH), .AXIS_W(AXIS_W), .LVL_W(LVL_W)) i_axis3_sample_fifo (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_z(smp_z), .trig_in(trig_in), .mode(mode), .level(level),
    .trig_sel(trig_sel), .pop(pop), .head_x(head_x), .head_y(head_y),
    .head_z(head_z), .count(count), .wmark(wmark), .busy(busy),
    .trig_taken(trig_taken), .irq_a(irq_a), .irq_b(irq_b)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Scoreboard: expected entries, oldest first
  logic [3*AXIS_W-1:0] sb[$];
  bit held = 1'b0;
  bit trimming = 1'b0;

  function automatic logic [3*AXIS_W-1:0] mk(int i);
    return {AXIS_W'(i), AXIS_W'(i + 'h1000), AXIS_W'(i + 'h2000)};
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare all outputs with the scoreboard
  task automatic monitor(string tag);
    bit tk;
    tk = held || trimming;
    chk(tag, "count", longint'(count), longint'(sb.size()));
    if (sb.size() > 0) chk(tag, "head", longint'({head_x, head_y, head_z}), longint'(sb[0]));
    chk(tag, "wmark", longint'(wmark),
        longint'((level != 0) && (sb.size() >= int'(level))));
    chk(tag, "busy", longint'(busy), longint'(trimming));
    chk(tag, "trig_taken", longint'(trig_taken), longint'(tk));
    chk(tag, "irq_a", longint'(irq_a), longint'(tk && !trig_sel));
    chk(tag, "irq_b", longint'(irq_b), longint'(tk && trig_sel));
  endtask

  // Driver: apply one cycle of stimulus and update expected contents
  task automatic cyc(string tag, bit v, int idx, bit p, bit t);
    bit full, fill_like;
    smp_valid = v;
    {smp_x, smp_y, smp_z} = mk(idx);
    pop = p;
    trig_in = t;
    if (mode == 2'b00) begin
      sb.delete();
      held = 1'b0;
      trimming = 1'b0;
    end else if (trimming) begin
      while (sb.size() > int'(level)) void'(sb.pop_front());
      trimming = 1'b0;
      held = 1'b1;
    end else begin
      full = (sb.size() == DEPTH);
      fill_like = (mode == 2'b01) || (mode == 2'b11 && held);
      if (p && sb.size() > 0) void'(sb.pop_front());
      if (v) begin
        if (fill_like) begin
          if (!full) sb.push_back(mk(idx));
        end else begin
          sb.push_back(mk(idx));
          if (sb.size() > DEPTH) void'(sb.pop_front());
        end
      end
      if (mode == 2'b11 && !held && t) trimming = 1'b1;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    pop = 1'b0;
    trig_in = 1'b0;
    monitor(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    monitor("R2");  // reset state

    // Fill mode, watermark at 4 (R6), fill to full (R1), overflow drops (R3)
    mode = 2'b01; level = 5'd4;
    for (int i = 0; i < 4; i++) cyc("R6", 1'b1, i, 1'b0, 1'b0);
    for (int i = 4; i < 32; i++) cyc("R1", 1'b1, i, 1'b0, 1'b0);
    for (int i = 32; i < 36; i++) cyc("R3", 1'b1, i, 1'b0, 1'b0);
    cyc("R3", 1'b1, 36, 1'b1, 1'b0);
    for (int k = 0; k < 29; k++) cyc("R6", 1'b0, 0, 1'b1, 1'b0);

    // Bypass clears and stores nothing (R2); empty pops ignored (R11)
    mode = 2'b00;
    cyc("R2", 1'b1, 50, 1'b0, 1'b0);
    cyc("R2", 1'b1, 51, 1'b1, 1'b0);
    mode = 2'b01;
    cyc("R11", 1'b0, 0, 1'b1, 1'b0);
    cyc("R11", 1'b0, 0, 1'b1, 1'b0);

    // Stream: wrap keeps newest 32 (R4); push+pop at full (R5)
    mode = 2'b10; level = 5'd8;
    for (int i = 100; i < 140; i++) cyc("R4", 1'b1, i, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) cyc("R5", 1'b1, 200 + k, 1'b1, 1'b0);
    level = 5'd0;
    cyc("R6", 1'b0, 0, 1'b0, 1'b0);
    cyc("R5", 1'b0, 0, 1'b1, 1'b0);

    // Trigger mode, route to irq_b, retain 5 of 32
    mode = 2'b00;
    cyc("R2", 1'b0, 0, 1'b0, 1'b0);
    mode = 2'b11; level = 5'd5; trig_sel = 1'b1;
    for (int i = 300; i < 340; i++) cyc("R7", 1'b1, i, 1'b0, 1'b0);
    cyc("R10", 1'b1, 400, 1'b0, 1'b1);
    cyc("R8", 1'b1, 401, 1'b1, 1'b0);
    cyc("R7", 1'b0, 0, 1'b0, 1'b0);
    for (int i = 500; i < 530; i++) cyc("R9", 1'b1, i, 1'b0, 1'b0);
    cyc("R9", 1'b0, 0, 1'b0, 1'b1);
    cyc("R9", 1'b0, 0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) cyc("R9", 1'b0, 0, 1'b1, 1'b0);

    // Re-arm through bypass, route to irq_a, fewer samples than the level
    mode = 2'b00;
    cyc("R10", 1'b0, 0, 1'b0, 1'b0);
    mode = 2'b11; trig_sel = 1'b0;
    for (int i = 600; i < 603; i++) cyc("R7", 1'b1, i, 1'b0, 1'b0);
    cyc("R10", 1'b0, 0, 1'b0, 1'b1);
    cyc("R8", 1'b0, 0, 1'b1, 1'b0);
    cyc("R7", 1'b0, 0, 1'b0, 1'b0);
    cyc("R10", 1'b0, 0, 1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule